// File: doc/BRIEF.md
# Masked Partial-Match Detector CAM

The block is a content addressable memory for detector words, used to spot illegal state-machine transitions at run time. Each entry holds a data word, a per-bit care mask and a valid flag. A search presents a key, and every stored entry is compared against it in the same cycle. The result is one hit line per entry plus a single `found` flag that is set when any entry hits.

A search also gives a comparison window as a start bit and a run length. Only bit positions inside that window can decide a hit. A hit then means agreement on a chosen run of adjacent bits (r-contiguous partial matching), not equality of the whole word. Bits whose stored mask is clear are don't-care as well. Entries are loaded through a simple write port. The comparison is built from 4-bit segments, and an entry hits only when all of its segments agree.

Top module: `detector_cam`

## Requirements
- R1: After reset every entry is invalid and `match_vec` and `found` are zero, so a search issued straight after reset returns all zeros.
- R2: A write with `wr_en` high stores `wr_data`, `wr_mask` and `wr_valid` at `wr_addr`, and a search issued in the following cycle sees the new contents, including at the highest address.
- R3: An entry whose valid flag is 0 never hits, whatever its data and the key; writing with `wr_valid`=0 removes a previously matching entry.
- R4: A stored mask bit of 1 makes that bit position take part in the comparison, and a mask bit of 0 makes it don't-care.
- R5: Only bit positions p with `win_start` <= p < `win_start`+`win_len` are compared; a mismatch outside that window does not prevent a hit.
- R6: A window that reaches past bit WIDTH-1 is cut at the word's top bit, so the positions above it add nothing.
- R7: A search sampled with `srch_en` high at a rising edge updates `match_vec` (bit k for entry k) and `found` (1 when any bit of `match_vec` is 1) at that same edge, so results are readable one cycle after the request is presented.
- R8: When `srch_en` is low at an edge, `match_vec` and `found` keep their previous values even if the key or window change.
- R9: A write and a search in the same cycle that target the same entry: the search is judged against the entry's contents from before the write.
- R10: Several entries can hit at once, and each of them sets its own bit of `match_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears valid flags and results |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 7 | Entry index to write |
| wr_data | input | 32 | Detector word to store |
| wr_mask | input | 32 | Care mask, 1 = compare this bit |
| wr_valid | input | 1 | Valid flag to store with the entry |
| srch_en | input | 1 | Search request strobe |
| srch_key | input | 32 | Key compared against all entries |
| win_start | input | 5 | Lowest bit position of the compare window |
| win_len | input | 6 | Window length in bits (1 to 32) |
| match_vec | output | 128 | One hit line per entry, registered |
| found | output | 1 | OR of all hit lines, registered |

## Verification
Both a write and a search can hit the same entry in one cycle. The bench provokes this by driving `wr_en` and `srch_en` together, with a key equal to the new data word and different from the old one. The expected result is computed from the scoreboard model before the model takes in the write, so a correct design reports a miss there and a hit on the next search. The same collision is also run the other way round, where an invalidating write meets a search that should still hit.

// File: rtl/cam_pkg.sv
package cam_pkg;

    // Width of one compare segment
    localparam int unsigned SEG_BITS = 4;

    // Number of segments needed to cover a word
    function automatic int unsigned seg_count(int unsigned width, int unsigned seg);
        return (width + seg - 1) / seg;
    endfunction

endpackage

// File: rtl/cam_window.sv
// Turns a start position and a run length into a per-bit care vector.
// Positions at or above start+len are excluded, which also clips at the top bit.
module cam_window #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned POS_W = 5,
    parameter int unsigned LEN_W = 6
) (
    input  logic [POS_W-1:0] win_start,
    input  logic [LEN_W-1:0] win_len,
    output logic [WIDTH-1:0] care
);
    localparam int unsigned SUM_W = LEN_W + 2;

    logic [SUM_W-1:0] lo;
    logic [SUM_W-1:0] hi;

    always_comb begin
        lo = SUM_W'(win_start);
        hi = SUM_W'(win_start) + SUM_W'(win_len);
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam logic [SUM_W-1:0] POS = SUM_W'(i);
        assign care[i] = (POS >= lo) && (POS < hi);
    end
endmodule

// File: rtl/cam_segment.sv
// One narrow compare slice: agrees when every active bit equals the key bit.
module cam_segment #(
    parameter int unsigned SEG_W = 4
) (
    input  logic [SEG_W-1:0] key,
    input  logic [SEG_W-1:0] data,
    input  logic [SEG_W-1:0] active,
    output logic             agree
);
    always_comb begin
        agree = ((key ^ data) & active) == '0;
    end
endmodule

// File: rtl/cam_row.sv
// Compare logic for one stored entry, built from narrow segments.
module cam_row #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned SEG_W = 4
) (
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] data,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] care,
    input  logic             valid,
    output logic             hit
);
    localparam int unsigned NSEG  = cam_pkg::seg_count(WIDTH, SEG_W);
    localparam int unsigned PAD_W = NSEG * SEG_W;

    logic [PAD_W-1:0] key_p;
    logic [PAD_W-1:0] data_p;
    logic [PAD_W-1:0] act_p;
    logic [NSEG-1:0]  seg_ok;

    always_comb begin
        key_p  = PAD_W'(key);
        data_p = PAD_W'(data);
        act_p  = PAD_W'(mask & care);
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        cam_segment #(.SEG_W(SEG_W)) u_seg (
            .key    (key_p[s*SEG_W +: SEG_W]),
            .data   (data_p[s*SEG_W +: SEG_W]),
            .active (act_p[s*SEG_W +: SEG_W]),
            .agree  (seg_ok[s])
        );
    end

    always_comb begin
        hit = valid && (&seg_ok);
    end
endmodule

// File: rtl/detector_cam.sv
module detector_cam #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 128,
    parameter int unsigned SEG_W = cam_pkg::SEG_BITS,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned POS_W  = $clog2(WIDTH),
    localparam int unsigned LEN_W  = $clog2(WIDTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  wr_mask,
    input  logic              wr_valid,
    input  logic              srch_en,
    input  logic [WIDTH-1:0]  srch_key,
    input  logic [POS_W-1:0]  win_start,
    input  logic [LEN_W-1:0]  win_len,
    output logic [DEPTH-1:0]  match_vec,
    output logic              found
);
    typedef struct packed {
        logic [DEPTH-1:0] hits;
        logic             any;
    } result_t;

    // Storage, split so that only the valid flags carry a reset
    logic [WIDTH-1:0] data_q [DEPTH];
    logic [WIDTH-1:0] data_d [DEPTH];
    logic [WIDTH-1:0] mask_q [DEPTH];
    logic [WIDTH-1:0] mask_d [DEPTH];
    logic [DEPTH-1:0] valid_q, valid_d;
    result_t          res_q, res_d;

    logic [WIDTH-1:0] care;
    logic [DEPTH-1:0] row_hit;

    cam_window #(.WIDTH(WIDTH), .POS_W(POS_W), .LEN_W(LEN_W)) u_window (
        .win_start (win_start),
        .win_len   (win_len),
        .care      (care)
    );

    // Every entry is compared against the key in parallel, using the contents from before any write in this cycle
    for (genvar k = 0; k < DEPTH; k++) begin : g_row
        cam_row #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_row (
            .key   (srch_key),
            .data  (data_q[k]),
            .mask  (mask_q[k]),
            .care  (care),
            .valid (valid_q[k]),
            .hit   (row_hit[k])
        );
    end

    always_comb begin
        data_d  = data_q;
        mask_d  = mask_q;
        valid_d = valid_q;
        res_d   = res_q;
        if (wr_en) begin
            data_d[wr_addr]  = wr_data;
            mask_d[wr_addr]  = wr_mask;
            valid_d[wr_addr] = wr_valid;
        end
        if (srch_en) begin
            res_d.hits = row_hit;
            res_d.any  = |row_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            res_q   <= '0;
        end else begin
            valid_q <= valid_d;
            res_q   <= res_d;
        end
    end

    always_ff @(posedge clk) begin
        data_q <= data_d;
        mask_q <= mask_d;
    end

    assign match_vec = res_q.hits;
    assign found     = res_q.any;

    // R2: the written entry holds what was presented on the write port
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_addr)] == $past(wr_valid))
                  && (data_q[$past(wr_addr)] == $past(wr_data))
                  && (mask_q[$past(wr_addr)] == $past(wr_mask)))
        else $error("write did not land");

    // R3: an entry that is invalid at search time reports no hit
    for (genvar k = 0; k < DEPTH; k++) begin : g_chk
        p_invalid_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (srch_en && !valid_q[k]) |=> !match_vec[k])
            else $error("invalid entry %0d hit", k);
    end

    // R7: found agrees with the hit lines
    p_found_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
        found == (match_vec != '0))
        else $error("found disagrees with hit lines");

    // R8: results hold while no search is requested
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> ($stable(match_vec) && $stable(found)))
        else $error("results changed without a search");
endmodule

// File: tb/detector_cam_tb.sv
module detector_cam_tb;
    localparam int W = 32;
    localparam int D = 128;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         wr_en = 0;
    logic [6:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] wr_mask = '0;
    logic         wr_valid = 0;
    logic         srch_en = 0;
    logic [W-1:0] srch_key = '0;
    logic [4:0]   win_start = '0;
    logic [5:0]   win_len = '0;
    logic [D-1:0] match_vec;
    logic         found;

    detector_cam u_dut (.*);

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench model of the stored entries
    logic [W-1:0] m_data [D];
    logic [W-1:0] m_mask [D];
    logic [D-1:0] m_valid = '0;

    typedef struct packed {
        logic [D-1:0] hits;
        logic         any;
    } exp_t;
    exp_t  exp_q [$];
    string tag_q [$];

    function automatic exp_t model(logic [W-1:0] key, int st, int ln);
        exp_t e;
        e.hits = '0;
        for (int k = 0; k < D; k++) begin
            bit ok = m_valid[k];
            for (int i = 0; i < W; i++)
                if (i >= st && i < st + ln && m_mask[k][i] && (m_data[k][i] != key[i]))
                    ok = 0;
            e.hits[k] = ok;
        end
        e.any = |e.hits;
        return e;
    endfunction

    task automatic check(string req, logic [D:0] act, logic [D:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Drive one cycle with optional write and optional search
    task automatic cycle(bit we, int addr, logic [W-1:0] dat, logic [W-1:0] msk, bit vld,
                         bit se, logic [W-1:0] key, int st, int ln, string req);
        @(negedge clk);
        wr_en = we; wr_addr = 7'(addr); wr_data = dat; wr_mask = msk; wr_valid = vld;
        srch_en = se; srch_key = key; win_start = 5'(st); win_len = 6'(ln);
        if (se) begin
            exp_q.push_back(model(key, st, ln));   // judged on pre-write contents
            tag_q.push_back(req);
        end
        if (we) begin
            m_data[addr] = dat; m_mask[addr] = msk; m_valid[addr] = vld;
        end
        @(negedge clk);
        wr_en = 0; srch_en = 0;
    endtask

    task automatic wr(int addr, logic [W-1:0] dat, logic [W-1:0] msk, bit vld);
        cycle(1, addr, dat, msk, vld, 0, '0, 0, 0, "");
    endtask

    task automatic sr(logic [W-1:0] key, int st, int ln, string req);
        cycle(0, 0, '0, '0, 0, 1, key, st, ln, req);
    endtask

    // Monitor: pops the expected result after each sampled search
    always @(posedge clk) begin
        if (rst_n && srch_en) begin
            exp_t e;
            string t;
            #2;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {match_vec, found}, {e.hits, e.any});
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [D-1:0] held;
        logic         held_f;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {match_vec, found}, '0);
        rst_n = 1;
        sr(32'h0, 0, 32, "R1");

        // R2, R7: exact hit and miss, highest address too
        wr(3, 32'hCAFE_0123, 32'hFFFF_FFFF, 1);
        sr(32'hCAFE_0123, 0, 32, "R2");
        sr(32'hCAFE_0122, 0, 32, "R7");
        wr(127, 32'h1357_9BDF, 32'hFFFF_FFFF, 1);
        sr(32'h1357_9BDF, 0, 32, "R2");

        // R4: mask clears the upper half
        wr(5, 32'h0000_ABCD, 32'h0000_FFFF, 1);
        sr(32'h7777_ABCD, 0, 32, "R4");
        sr(32'h7777_ABCC, 0, 32, "R4");

        // R5: window selects which bits decide
        wr(7, 32'h00F0_0000, 32'hFFFF_FFFF, 1);
        sr(32'h00E0_0000, 0, 16, "R5");
        sr(32'h00E0_0000, 16, 8, "R5");
        sr(32'h00F0_0001, 4, 20, "R5");

        // R6: window past the top bit is clipped
        wr(8, 32'hA000_0000, 32'hFFFF_FFFF, 1);
        sr(32'hA000_0008, 28, 32, "R6");
        sr(32'hA000_0008, 2, 32, "R6");

        // R3: invalidate a matching entry
        wr(3, 32'hCAFE_0123, 32'hFFFF_FFFF, 0);
        sr(32'hCAFE_0123, 0, 32, "R3");

        // R9: write and search collide on one entry
        wr(9, 32'h1111_1111, 32'hFFFF_FFFF, 1);
        cycle(1, 9, 32'h2222_2222, 32'hFFFF_FFFF, 1, 1, 32'h2222_2222, 0, 32, "R9");
        sr(32'h2222_2222, 0, 32, "R9");
        cycle(1, 9, 32'h2222_2222, 32'hFFFF_FFFF, 0, 1, 32'h2222_2222, 0, 32, "R9");
        sr(32'h2222_2222, 0, 32, "R9");

        // R10: several entries hit together
        wr(10, 32'h5A5A_5A5A, 32'hFFFF_FFFF, 1);
        wr(11, 32'h5A5A_0000, 32'hFFFF_0000, 1);
        wr(12, 32'h5A5A_5A5B, 32'hFFFF_FFFF, 1);
        sr(32'h5A5A_5A5A, 0, 32, "R10");
        sr(32'h5A5A_5A5A, 1, 31, "R10");

        // R8: idle cycles keep the last result
        @(negedge clk);
        held = match_vec; held_f = found;
        srch_key = 32'h0; win_start = 5'd0; win_len = 6'd0;
        repeat (4) @(negedge clk);
        check("R8", {match_vec, found}, {held, held_f});
        check("R8", {1'b0, held_f}, {1'b0, 1'b1});

        repeat (3) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule